// File: doc/BRIEF.md
# Parallel Port Interrupt Gating Controller

This block is the control path of a three-port parallel I/O interface, reduced to what decides when the host is interrupted. A single host write bus reaches three registers. The configuration register takes either a mode word or a one-bit update of the port C enable flags. The port-select register picks which ports may interrupt. The global register holds a master interrupt enable. Port data paths and the plain (handshake-free) mode are left out.

Port A supports a single-direction strobed mode and a mode 2 whose direction comes from the mode word. Port B supports only the strobed mode. In the output direction, a host data write marks the output buffer full, and the external acknowledge empties it. In the input direction, the external strobe fills the input buffer, and a host read empties it. The trailing edge of acknowledge or strobe raises the port's request, but only when the matching port C enable flag is set. A request reaches the single host interrupt line only when three things are set: its port C flag, its port-select bit and the global enable.

Top module: `ppi_irq_gate`

## Requirements
- R1: After reset, all buffer flags, both port requests and `host_irq` are low, and both ports are in the handshake-free mode.
- R2: A configuration write (address 0) with bit 7 set is a mode word. Bits 6:5 set the port A mode: 00 is none, 01 is strobed, 1x is mode 2. Bit 4 set makes port A an input. Bit 2 set puts port B in strobed mode. Bit 1 set makes port B an input. The write also clears all three port C enable flags and every buffer flag and request on the next edge.
- R3: A configuration write with bit 7 clear updates one port C flag. Bits 3:1 give the bit index and bit 0 the new value. Only indices 2, 4 and 6 hold state; any other index changes nothing.
- R4: For an output port, a host data write sets out-full and clears the request on the next edge. A sampled low `*_ack_n` clears out-full. A low-to-high change of `*_ack_n` sets the request on that edge if the port's enable flag is set.
- R5: For an input port, a sampled low `*_stb_n` sets in-full. A low-to-high change of `*_stb_n` sets the request if the port's enable flag is set. A host read clears both in-full and the request.
- R6: Port B uses flag PC2 in both directions. Port A uses PC6 when it is an output and PC4 when it is an input. A trailing edge while the selected flag is clear raises no request.
- R7: A port in the handshake-free mode ignores its strobe, acknowledge, host write and host read. Its flags and request stay low.
- R8: `host_irq` = global enable (address 2, bit 2) AND ((port A request AND select bit 0) OR (port B request AND select bit 1)). The select bits are at address 1. The output follows register changes in the same cycle they are written.
- R9: Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 config, 1 select, 2 global) |
| reg_wdata | input | 8 | Register write data |
| pa_host_wr | input | 1 | Host wrote port A data |
| pa_host_rd | input | 1 | Host read port A data |
| pb_host_wr | input | 1 | Host wrote port B data |
| pb_host_rd | input | 1 | Host read port B data |
| pa_stb_n | input | 1 | Port A input strobe, active low |
| pa_ack_n | input | 1 | Port A output acknowledge, active low |
| pb_stb_n | input | 1 | Port B input strobe, active low |
| pb_ack_n | input | 1 | Port B output acknowledge, active low |
| pa_out_full | output | 1 | Port A output buffer full |
| pa_in_full | output | 1 | Port A input buffer full |
| pa_req | output | 1 | Port A interrupt request |
| pb_out_full | output | 1 | Port B output buffer full |
| pb_in_full | output | 1 | Port B input buffer full |
| pb_req | output | 1 | Port B interrupt request |
| host_irq | output | 1 | Gated host interrupt |

## Verification
The hardest case to reach is one where the right handshake edge arrives but the wrong enable flag is armed. Examples are port A in the input direction with only PC6 set, or a flag set through an index that has no state. This can only be seen as a request that fails to appear. The stimulus builds it through the configuration port in three steps: a mode word to clear the flags, a bit update to arm the other flag, then a complete strobe or acknowledge cycle. The stimulus then re-arms the correct flag and repeats the same cycle, to show that the missing request came from the flag choice alone. Mode words are also sent while both a full flag and a request are pending, to show that they clear together.

// File: rtl/ppi_irq_pkg.sv
`timescale 1ns/1ps
package ppi_irq_pkg;
    localparam int NPORTS      = 2;
    localparam int PORT_A      = 0;
    localparam int PORT_B      = 1;
    // positions inside the host-visible words
    localparam int MODE_FLAG   = 7;
    localparam int GLOBAL_BIT  = 2;
    // indices of the stored port C enable flags
    localparam int PCF_B       = 0;   // PC2
    localparam int PCF_A_IN    = 1;   // PC4
    localparam int PCF_A_OUT   = 2;   // PC6
    localparam int NPCF        = 3;

    typedef struct packed {
        logic [1:0] a_mode;
        logic       a_in;
        logic       b_mode;
        logic       b_in;
    } mode_t;

    typedef struct packed {
        mode_t             mode;
        logic [NPCF-1:0]   pc_en;
        logic [NPORTS-1:0] sel;
        logic              gen;
    } cfg_t;

    typedef struct packed {
        logic out_full;
        logic in_full;
        logic req;
        logic stb_prev;
        logic ack_prev;
    } hs_t;

    function automatic mode_t decode_mode(input logic [7:0] w);
        mode_t m;
        m.a_mode = w[6:5];
        m.a_in   = w[4];
        m.b_mode = w[2];
        m.b_in   = w[1];
        return m;
    endfunction
endpackage

// File: rtl/ppi_cfg_regs.sv
`timescale 1ns/1ps
module ppi_cfg_regs
    import ppi_irq_pkg::*;
#(
    parameter int                ADDR_W   = 2,
    parameter logic [ADDR_W-1:0] ADDR_CFG = 0,
    parameter logic [ADDR_W-1:0] ADDR_SEL = 1,
    parameter logic [ADDR_W-1:0] ADDR_GEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output cfg_t              cfg,
    output logic              mode_clr
);
    cfg_t cfg_d, cfg_q;
    logic clr_d;

    always_comb begin
        cfg_d = cfg_q;
        clr_d = 1'b0;
        if (reg_wr) begin
            if (reg_addr == ADDR_CFG) begin
                if (reg_wdata[MODE_FLAG]) begin
                    cfg_d.mode  = decode_mode(reg_wdata);
                    cfg_d.pc_en = '0;
                    clr_d       = 1'b1;
                end else begin
                    case (reg_wdata[3:1])
                        3'd2:    cfg_d.pc_en[PCF_B]     = reg_wdata[0];
                        3'd4:    cfg_d.pc_en[PCF_A_IN]  = reg_wdata[0];
                        3'd6:    cfg_d.pc_en[PCF_A_OUT] = reg_wdata[0];
                        default: ;
                    endcase
                end
            end else if (reg_addr == ADDR_SEL) begin
                cfg_d.sel = reg_wdata[NPORTS-1:0];
            end else if (reg_addr == ADDR_GEN) begin
                cfg_d.gen = reg_wdata[GLOBAL_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg      = cfg_q;
    assign mode_clr = clr_d;

    // R3: port C flags move only on a configuration write
    assert_pcf_only_on_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_CFG) |=> $stable(cfg_q.pc_en));
    // R2: a mode word leaves every port C flag cleared
    assert_mode_clears_pcf_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CFG && reg_wdata[MODE_FLAG]) |=> (cfg_q.pc_en == '0));
endmodule

// File: rtl/ppi_hs_port.sv
`timescale 1ns/1ps
module ppi_hs_port
    import ppi_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic active,
    input  logic dir_in,
    input  logic inte,
    input  logic host_wr,
    input  logic host_rd,
    input  logic stb_n,
    input  logic ack_n,
    output logic out_full,
    output logic in_full,
    output logic req
);
    hs_t st_d, st_q;
    logic stb_trail, ack_trail;

    assign stb_trail = stb_n & ~st_q.stb_prev;
    assign ack_trail = ack_n & ~st_q.ack_prev;

    always_comb begin
        st_d          = st_q;
        st_d.stb_prev = stb_n;
        st_d.ack_prev = ack_n;
        if (clr) begin
            st_d.out_full = 1'b0;
            st_d.in_full  = 1'b0;
            st_d.req      = 1'b0;
        end else if (active) begin
            if (dir_in) begin
                if (!stb_n)             st_d.in_full = 1'b1;
                if (host_rd) begin
                    st_d.in_full = 1'b0;
                    st_d.req     = 1'b0;
                end
                if (stb_trail && inte)  st_d.req = 1'b1;
            end else begin
                if (!ack_n)             st_d.out_full = 1'b0;
                if (host_wr) begin
                    st_d.out_full = 1'b1;
                    st_d.req      = 1'b0;
                end
                if (ack_trail && inte)  st_d.req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.stb_prev <= 1'b1;
            st_q.ack_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_full = st_q.out_full;
    assign in_full  = st_q.in_full;
    assign req      = st_q.req;

    // R2: a mode word clears flags and request
    assert_mode_clears_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!out_full && !in_full && !req));
    // R5: a host read empties the input buffer
    assert_read_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && active && dir_in && host_rd) |=> !in_full);
    // R6: a request only appears while its enable flag was set
    assert_req_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(inte));
    // R7: an inactive port never holds a request
    assert_idle_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !req);
endmodule

// File: rtl/ppi_irq_merge.sv
`timescale 1ns/1ps
module ppi_irq_merge #(
    parameter int N = 2
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] sel,
    input  logic         gen,
    output logic         irq
);
    assign irq = gen & (|(req & sel));
endmodule

// File: rtl/ppi_irq_gate.sv
`timescale 1ns/1ps
module ppi_irq_gate
    import ppi_irq_pkg::*;
#(
    parameter int                ADDR_W   = 2,
    parameter logic [ADDR_W-1:0] ADDR_CFG = 0,
    parameter logic [ADDR_W-1:0] ADDR_SEL = 1,
    parameter logic [ADDR_W-1:0] ADDR_GEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              pa_host_wr,
    input  logic              pa_host_rd,
    input  logic              pb_host_wr,
    input  logic              pb_host_rd,
    input  logic              pa_stb_n,
    input  logic              pa_ack_n,
    input  logic              pb_stb_n,
    input  logic              pb_ack_n,
    output logic              pa_out_full,
    output logic              pa_in_full,
    output logic              pa_req,
    output logic              pb_out_full,
    output logic              pb_in_full,
    output logic              pb_req,
    output logic              host_irq
);
    cfg_t cfg;
    logic mode_clr;

    logic [NPORTS-1:0] p_active, p_dir_in, p_inte;
    logic [NPORTS-1:0] p_wr, p_rd, p_stb_n, p_ack_n;
    logic [NPORTS-1:0] p_out_full, p_in_full, p_req;

    ppi_cfg_regs #(
        .ADDR_W(ADDR_W), .ADDR_CFG(ADDR_CFG), .ADDR_SEL(ADDR_SEL), .ADDR_GEN(ADDR_GEN)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cfg(cfg), .mode_clr(mode_clr)
    );

    assign p_active[PORT_A] = (cfg.mode.a_mode != 2'b00);
    assign p_dir_in[PORT_A] = cfg.mode.a_in;
    assign p_inte[PORT_A]   = cfg.mode.a_in ? cfg.pc_en[PCF_A_IN] : cfg.pc_en[PCF_A_OUT];
    assign p_active[PORT_B] = cfg.mode.b_mode;
    assign p_dir_in[PORT_B] = cfg.mode.b_in;
    assign p_inte[PORT_B]   = cfg.pc_en[PCF_B];

    assign p_wr    = {pb_host_wr, pa_host_wr};
    assign p_rd    = {pb_host_rd, pa_host_rd};
    assign p_stb_n = {pb_stb_n,   pa_stb_n};
    assign p_ack_n = {pb_ack_n,   pa_ack_n};

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        ppi_hs_port u_hs (
            .clk(clk), .rst_n(rst_n), .clr(mode_clr),
            .active(p_active[i]), .dir_in(p_dir_in[i]), .inte(p_inte[i]),
            .host_wr(p_wr[i]), .host_rd(p_rd[i]),
            .stb_n(p_stb_n[i]), .ack_n(p_ack_n[i]),
            .out_full(p_out_full[i]), .in_full(p_in_full[i]), .req(p_req[i])
        );
    end

    ppi_irq_merge #(.N(NPORTS)) u_merge (
        .req(p_req), .sel(cfg.sel), .gen(cfg.gen), .irq(host_irq)
    );

    assign pa_out_full = p_out_full[PORT_A];
    assign pa_in_full  = p_in_full[PORT_A];
    assign pa_req      = p_req[PORT_A];
    assign pb_out_full = p_out_full[PORT_B];
    assign pb_in_full  = p_in_full[PORT_B];
    assign pb_req      = p_req[PORT_B];

    // R8: the host line never rises without a port request behind it
    assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (pa_req || pb_req));
endmodule

// File: tb/ppi_irq_gate_bench.sv
`timescale 1ns/1ps
module ppi_irq_gate_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic pa_host_wr = 1'b0, pa_host_rd = 1'b0, pb_host_wr = 1'b0, pb_host_rd = 1'b0;
    logic pa_stb_n = 1'b1, pa_ack_n = 1'b1, pb_stb_n = 1'b1, pb_ack_n = 1'b1;
    logic pa_out_full, pa_in_full, pa_req, pb_out_full, pb_in_full, pb_req, host_irq;

    always #2 clk = ~clk;

    ppi_irq_gate u_ppi_irq_gate (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .pa_host_wr(pa_host_wr), .pa_host_rd(pa_host_rd),
        .pb_host_wr(pb_host_wr), .pb_host_rd(pb_host_rd),
        .pa_stb_n(pa_stb_n), .pa_ack_n(pa_ack_n), .pb_stb_n(pb_stb_n), .pb_ack_n(pb_ack_n),
        .pa_out_full(pa_out_full), .pa_in_full(pa_in_full), .pa_req(pa_req),
        .pb_out_full(pb_out_full), .pb_in_full(pb_in_full), .pb_req(pb_req),
        .host_irq(host_irq)
    );

    // observed vector: [6]irq [5]b_req [4]b_in [3]b_out [2]a_req [1]a_in [0]a_out
    logic [6:0] obs;
    assign obs = {host_irq, pb_req, pb_in_full, pb_out_full, pa_req, pa_in_full, pa_out_full};

    typedef struct { string tag; logic [6:0] v; } item_t;
    item_t sbq[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // monitor: one expected item per clock edge
    always @(posedge clk) begin
        item_t it;
        #1;
        if (sbq.size() > 0) begin
            it = sbq.pop_front();
            n_vec++;
            if (obs !== it.v) begin
                n_bad++;
                $display("FAIL %s: got %b expected %b", it.tag, obs, it.v);
            end
        end
    end

    task automatic cyc(input string tag, input logic [6:0] v);
        item_t it;
        it.tag = tag;
        it.v   = v;
        sbq.push_back(it);
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        pa_host_wr = 1'b0; pa_host_rd = 1'b0;
        pb_host_wr = 1'b0; pb_host_rd = 1'b0;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d,
                        input string tag, input logic [6:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc(tag, v);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc("R1 reset", 7'b0000000);

        // port B strobed output
        wreg(0, 8'h84, "R2 mode B out", 7'b0000000);
        wreg(0, 8'h05, "R3 set PC2", 7'b0000000);
        wreg(1, 8'h02, "R8 select B", 7'b0000000);
        wreg(2, 8'h04, "R8 global on", 7'b0000000);
        pb_host_wr = 1'b1; cyc("R4 write fills", 7'b0001000);
        pb_ack_n = 1'b0;   cyc("R4 ack empties", 7'b0000000);
        pb_ack_n = 1'b1;   cyc("R4 ack trail req", 7'b1100000);
        wreg(2, 8'h00, "R8 global off", 7'b0100000);
        wreg(2, 8'h04, "R8 global on", 7'b1100000);
        wreg(1, 8'h01, "R8 select A only", 7'b0100000);
        wreg(1, 8'h02, "R8 select B", 7'b1100000);
        wreg(3, 8'h80, "R9 addr3 ignored", 7'b1100000);
        pb_host_wr = 1'b1; cyc("R4 write clears req", 7'b0001000);
        wreg(0, 8'h04, "R3 clear PC2", 7'b0001000);
        pb_ack_n = 1'b0;   cyc("R6 ack low", 7'b0000000);
        pb_ack_n = 1'b1;   cyc("R6 no req PC2 clear", 7'b0000000);
        wreg(0, 8'h07, "R3 index3 set", 7'b0000000);
        pb_host_wr = 1'b1; cyc("R3 write", 7'b0001000);
        pb_ack_n = 1'b0;   cyc("R3 ack low", 7'b0000000);
        pb_ack_n = 1'b1;   cyc("R3 index3 no enable", 7'b0000000);

        // both ports handshake-free
        wreg(0, 8'h80, "R7 mode none", 7'b0000000);
        wreg(0, 8'h05, "R7 set PC2", 7'b0000000);
        pb_host_wr = 1'b1; cyc("R7 write ignored", 7'b0000000);
        pb_stb_n = 1'b0;   cyc("R7 stb ignored", 7'b0000000);
        pb_stb_n = 1'b1;   cyc("R7 stb trail ignored", 7'b0000000);
        pa_stb_n = 1'b0;   cyc("R7 A stb ignored", 7'b0000000);
        pa_stb_n = 1'b1;   cyc("R7 A trail ignored", 7'b0000000);

        // port A mode 2 input
        wreg(0, 8'hD0, "R2 mode2 A in", 7'b0000000);
        wreg(0, 8'h09, "R3 set PC4", 7'b0000000);
        wreg(1, 8'h01, "R8 select A", 7'b0000000);
        pa_stb_n = 1'b0;   cyc("R5 stb fills", 7'b0000010);
        pa_stb_n = 1'b1;   cyc("R5 stb trail req", 7'b1000110);
        wreg(0, 8'hD0, "R2 mode word clears", 7'b0000000);
        pa_stb_n = 1'b0;   cyc("R2 stb fills", 7'b0000010);
        pa_stb_n = 1'b1;   cyc("R2 PC4 was cleared", 7'b0000010);
        pa_host_rd = 1'b1; cyc("R5 read empties", 7'b0000000);
        wreg(0, 8'h09, "R3 set PC4", 7'b0000000);
        pa_stb_n = 1'b0;   cyc("R5 stb fills", 7'b0000010);
        pa_stb_n = 1'b1;   cyc("R5 stb trail req", 7'b1000110);
        pa_host_rd = 1'b1; cyc("R5 read clears both", 7'b0000000);
        wreg(0, 8'h08, "R3 clear PC4", 7'b0000000);
        wreg(0, 8'h0D, "R3 set PC6", 7'b0000000);
        pa_stb_n = 1'b0;   cyc("R6 stb fills", 7'b0000010);
        pa_stb_n = 1'b1;   cyc("R6 PC6 not for input", 7'b0000010);
        pa_host_rd = 1'b1; cyc("R5 read empties", 7'b0000000);

        // port A mode 2 output
        wreg(0, 8'hC0, "R2 mode2 A out", 7'b0000000);
        wreg(0, 8'h0D, "R3 set PC6", 7'b0000000);
        pa_host_wr = 1'b1; cyc("R4 A write fills", 7'b0000001);
        pa_ack_n = 1'b0;   cyc("R4 A ack empties", 7'b0000000);
        pa_ack_n = 1'b1;   cyc("R4 A ack trail req", 7'b1000100);
        pa_host_wr = 1'b1; cyc("R4 A write clears req", 7'b0000001);

        // port A strobed output with only PC4 armed
        wreg(0, 8'hA0, "R2 mode1 A out", 7'b0000000);
        wreg(0, 8'h09, "R3 set PC4", 7'b0000000);
        pa_host_wr = 1'b1; cyc("R6 A write", 7'b0000001);
        pa_ack_n = 1'b0;   cyc("R6 A ack low", 7'b0000000);
        pa_ack_n = 1'b1;   cyc("R6 PC4 not for output", 7'b0000000);

        // port B strobed input
        wreg(0, 8'h86, "R2 mode B in", 7'b0000000);
        wreg(0, 8'h05, "R3 set PC2", 7'b0000000);
        wreg(1, 8'h02, "R8 select B", 7'b0000000);
        pb_stb_n = 1'b0;   cyc("R5 B stb fills", 7'b0010000);
        pb_stb_n = 1'b1;   cyc("R5 B trail req", 7'b1110000);
        pb_host_rd = 1'b1; cyc("R5 B read clears", 7'b0000000);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule